// File: doc/BRIEF.md
# External Memory Bus Controller with Four Chip-Select Windows

This block turns requests from an internal request/acknowledge port into cycles on an external asynchronous memory bus. Each request carries a 24-bit byte address, write data, a byte or halfword size and a direction. The controller compares the address against four windows, each set by a base and a mask at a granularity of 64 KB. It drives the active-low chip-select of the winning window for the length of the bus cycle. Read data is collected from the external data input and returned with the acknowledge.

Each window has its own count of inserted wait clocks and its own data width, 8 or 16 bits. A halfword access to an 8-bit window becomes two back-to-back bus cycles. The low byte goes to the request address and the high byte to the next address. After the programmed waits, an external ready input stretches the cycle for as long as it stays low. An address that hits no window produces no bus activity and is acknowledged with an error flag.

The sequencer has five states. IDLE waits for a request. On a window hit it moves to SETUP, and on a miss it moves to FAIL. SETUP is the first bus clock: the address and chip-select are driven and the wait counter is loaded. SETUP always moves to STROBE. STROBE drives the write strobe and holds while waits remain or ready is low. When it ends, STROBE returns to SETUP for the second half of a split access, or otherwise moves to DONE. DONE and FAIL each raise the acknowledge for one clock and then move to IDLE.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: `ext_addr` carries the request address during the bus cycle. It carries address+1 (wrapping at 24 bits) during the second cycle of a split access, and it does not change while `ext_we_n` is low.
- R2: Window n matches when `((addr ^ base_n) & mask_n)` is zero in bits 23..16. Mask bits 15..0 are ignored. Only the chip-select of the selected window goes low, and never more than one at a time.
- R3: When several windows match, the lowest-numbered window is selected.
- R4: An address that matches no window asserts no chip-select and no strobe. It is acknowledged with `req_err` high.
- R5: With zero wait clocks and ready high, a bus cycle keeps its chip-select low for exactly 2 clocks.
- R6: With a wait count w (4 bits per window, held in `cfg_wait[4n+3:4n]`), a bus cycle with ready high lasts w+2 clocks.
- R7: `ext_rdy` is sampled only after the programmed waits have elapsed. The cycle ends on the first rising edge after that point at which ready is high. A low ready during the waits has no effect.
- R8: `ext_cs_n`, `ext_oe_n` and `ext_we_n` are active low. On a read, `ext_oe_n` is low for every clock of the cycle and `ext_we_n` stays high. On a write, `ext_oe_n` stays high and `ext_we_n` is low in every clock of the cycle except the first.
- R9: `cfg_wide[n]=1` marks window n as 16 bits wide. A halfword (`req_size`=1) on such a window is a single cycle that uses all 16 data lanes.
- R10: A halfword on an 8-bit window (`cfg_wide[n]=0`) is split into two cycles. The low byte is transferred first at the address, then the high byte at address+1, both on lanes 7..0. The read result is {second byte, first byte}.
- R11: A byte access (`req_size`=0) uses lanes 7..0 in one cycle and returns read data with bits 15..8 zero.
- R12: `req_ack` is high for exactly one clock, in the clock after the final bus cycle ends. `req_rdata` holds the assembled read data during that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 96 | Window base addresses, window n in bits 24n+23..24n |
| cfg_mask | input | 96 | Window masks, same layout; bits 15..0 of each are ignored |
| cfg_wait | input | 16 | Wait clocks per window, 4 bits each |
| cfg_wide | input | 4 | Per-window data width, 1 = 16 bits, 0 = 8 bits |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = halfword |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| req_err | output | 1 | Request hit no window, valid with `req_ack` |
| req_rdata | output | 16 | Read data, valid with `req_ack` |
| ext_addr | output | 24 | External address |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_oe_n | output | 1 | Output enable, active low |
| ext_we_n | output | 1 | Write enable, active low |
| ext_cs_n | output | 4 | Chip-selects, active low |
| ext_rdy | input | 1 | External ready, low stretches the cycle |

## Verification
Requests are aimed at each window and at unmapped space. An overlap region separates priority from simple matching, and a window whose mask has low bits set shows that the 64 KB granularity is enforced. Wait counts of 0, 2 and 5 show that the cycle length follows the selected window. Byte and halfword accesses on 8-bit and 16-bit windows tell the single-cycle path from the split path, including splits whose second address crosses a 1 MB boundary or wraps at the top of the space. Ready is held low for several clocks against a zero-wait window and against a long-wait window, which shows whether ready extends the cycle only once the programmed waits are used up.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int NUM_WIN = 4;
    localparam int WAIT_W  = 4;
    localparam int GRAIN_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_DONE,
        ST_FAIL
    } bus_state_e;
endpackage

// File: rtl/ebc_decode.sv
module ebc_decode #(
    parameter int NUM_WIN = ebc_pkg::NUM_WIN,
    parameter int ADDR_W  = ebc_pkg::ADDR_W,
    parameter int GRAIN_W = ebc_pkg::GRAIN_W,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_WIN*ADDR_W-1:0] cfg_base,
    input  logic [NUM_WIN*ADDR_W-1:0] cfg_mask,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);
    localparam logic [ADDR_W-1:0] KEEP = {{(ADDR_W-GRAIN_W){1'b1}}, {GRAIN_W{1'b0}}};

    logic [NUM_WIN-1:0] match;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [ADDR_W-1:0] diff;
        assign diff     = (addr ^ cfg_base[g*ADDR_W +: ADDR_W]) & cfg_mask[g*ADDR_W +: ADDR_W] & KEEP;
        assign match[g] = (diff == '0);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq #(
    parameter int NUM_WIN = ebc_pkg::NUM_WIN,
    parameter int ADDR_W  = ebc_pkg::ADDR_W,
    parameter int DATA_W  = ebc_pkg::DATA_W,
    parameter int WAIT_W  = ebc_pkg::WAIT_W,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_WIN*WAIT_W-1:0] cfg_wait,
    input  logic [NUM_WIN-1:0]        cfg_wide,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_size,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic                      hit,
    input  logic [IDX_W-1:0]          hit_idx,
    output logic                      req_ack,
    output logic                      req_err,
    output logic [DATA_W-1:0]         req_rdata,
    output logic [ADDR_W-1:0]         ext_addr,
    output logic [DATA_W-1:0]         ext_dout,
    input  logic [DATA_W-1:0]         ext_din,
    output logic                      ext_oe_n,
    output logic                      ext_we_n,
    output logic [NUM_WIN-1:0]        ext_cs_n,
    input  logic                      ext_rdy
);
    import ebc_pkg::*;

    bus_state_e         state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               write_q;
    logic               size_q;
    logic               phase_q;
    logic [IDX_W-1:0]   win_q;
    logic [WAIT_W-1:0]  cnt_q;

    logic [WAIT_W-1:0]  wait_sel;
    logic               wide_sel;
    logic               split;
    logic               end_cyc;

    assign wait_sel = cfg_wait[win_q*WAIT_W +: WAIT_W];
    assign wide_sel = cfg_wide[win_q];
    assign split    = size_q & ~wide_sel;
    assign end_cyc  = (state_q == ST_STROBE) && (cnt_q == '0) && ext_rdy;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = hit ? ST_SETUP : ST_FAIL;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (end_cyc) state_d = (split && !phase_q) ? ST_SETUP : ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            write_q <= 1'b0;
            size_q  <= 1'b0;
            phase_q <= 1'b0;
            win_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                size_q  <= req_size;
                win_q   <= hit_idx;
                phase_q <= 1'b0;
                rdata_q <= '0;
            end
            if (state_q == ST_SETUP) cnt_q <= wait_sel;
            if (state_q == ST_STROBE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (end_cyc) begin
                if (!write_q) begin
                    if (size_q && wide_sel)  rdata_q <= ext_din;
                    else if (!phase_q)       rdata_q <= {{HALF_W{1'b0}}, ext_din[HALF_W-1:0]};
                    else                     rdata_q[DATA_W-1:HALF_W] <= ext_din[HALF_W-1:0];
                end
                if (split && !phase_q) phase_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ext_cs_n  = '1;
        ext_oe_n  = 1'b1;
        ext_we_n  = 1'b1;
        req_ack   = 1'b0;
        req_err   = 1'b0;
        unique case (state_q)
            ST_SETUP: begin
                ext_cs_n[win_q] = 1'b0;
                ext_oe_n        = write_q;
            end
            ST_STROBE: begin
                ext_cs_n[win_q] = 1'b0;
                ext_oe_n        = write_q;
                ext_we_n        = ~write_q;
            end
            ST_DONE:  req_ack = 1'b1;
            ST_FAIL: begin
                req_ack = 1'b1;
                req_err = 1'b1;
            end
            default: ;
        endcase
        ext_addr  = addr_q + ADDR_W'(phase_q);
        if (size_q && wide_sel) ext_dout = wdata_q;
        else if (phase_q)       ext_dout = {{HALF_W{1'b0}}, wdata_q[DATA_W-1:HALF_W]};
        else                    ext_dout = {{HALF_W{1'b0}}, wdata_q[HALF_W-1:0]};
        req_rdata = rdata_q;
    end
endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl #(
    parameter int NUM_WIN = ebc_pkg::NUM_WIN,
    parameter int ADDR_W  = ebc_pkg::ADDR_W,
    parameter int DATA_W  = ebc_pkg::DATA_W,
    parameter int WAIT_W  = ebc_pkg::WAIT_W,
    parameter int GRAIN_W = ebc_pkg::GRAIN_W,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_WIN*ADDR_W-1:0] cfg_base,
    input  logic [NUM_WIN*ADDR_W-1:0] cfg_mask,
    input  logic [NUM_WIN*WAIT_W-1:0] cfg_wait,
    input  logic [NUM_WIN-1:0]        cfg_wide,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_size,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      req_ack,
    output logic                      req_err,
    output logic [DATA_W-1:0]         req_rdata,
    output logic [ADDR_W-1:0]         ext_addr,
    output logic [DATA_W-1:0]         ext_dout,
    input  logic [DATA_W-1:0]         ext_din,
    output logic                      ext_oe_n,
    output logic                      ext_we_n,
    output logic [NUM_WIN-1:0]        ext_cs_n,
    input  logic                      ext_rdy
);
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    ebc_decode #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W),
        .GRAIN_W (GRAIN_W)
    ) u_decode (
        .addr     (req_addr),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    ebc_seq #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .WAIT_W  (WAIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wait  (cfg_wait),
        .cfg_wide  (cfg_wide),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .req_ack   (req_ack),
        .req_err   (req_err),
        .req_rdata (req_rdata),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .ext_din   (ext_din),
        .ext_oe_n  (ext_oe_n),
        .ext_we_n  (ext_we_n),
        .ext_cs_n  (ext_cs_n),
        .ext_rdy   (ext_rdy)
    );
endmodule

// File: rtl/ebc_bus_ctrl_chk.sv
module ebc_bus_ctrl_chk #(
    parameter int NUM_WIN = ebc_pkg::NUM_WIN,
    parameter int ADDR_W  = ebc_pkg::ADDR_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ack,
    input logic               req_err,
    input logic [ADDR_W-1:0]  ext_addr,
    input logic               ext_oe_n,
    input logic               ext_we_n,
    input logic [NUM_WIN-1:0] ext_cs_n
);
    logic cs_any;
    assign cs_any = (ext_cs_n != '1);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ext_cs_n)); // R2
    AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) req_err |-> (req_ack && !cs_any && ext_we_n && ext_oe_n)); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!ext_oe_n && !ext_we_n)); // R8
    AST_WE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) !ext_we_n |-> cs_any); // R8
    AST_WE_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_any) |-> ext_we_n); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!ext_we_n && $past(!ext_we_n)) |-> $stable(ext_addr)); // R1
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack); // R12
    AST_ACK_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) req_ack |-> !cs_any); // R12
endmodule

bind ebc_bus_ctrl ebc_bus_ctrl_chk #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ack  (req_ack),
    .req_err  (req_err),
    .ext_addr (ext_addr),
    .ext_oe_n (ext_oe_n),
    .ext_we_n (ext_we_n),
    .ext_cs_n (ext_cs_n)
);

// File: tb/tb_ebc_bus_ctrl.sv
module tb_ebc_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [95:0] BASE = {24'h800000, 24'h120000, 24'h100000, 24'h000000};
    localparam logic [95:0] MASK = {24'h80FFFF, 24'hFF0000, 24'hF00000, 24'hFF0000};
    localparam logic [15:0] WAIT = {4'd5, 4'd1, 4'd2, 4'd0};
    localparam logic [3:0]  WIDE = 4'b0101;
    localparam logic [2:0]  NONE = 3'd7;

    typedef struct packed {
        logic [23:0] addr;
        logic        wr;
        logic        sz;
        logic [15:0] wdata;
        logic [2:0]  win;
        logic [4:0]  clks;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{24'h001234, 1'b0, 1'b1, 16'h0000, 3'd0, 5'd2},
        '{24'h00FFFE, 1'b1, 1'b1, 16'hBEEF, 3'd0, 5'd2},
        '{24'h100010, 1'b0, 1'b1, 16'h0000, 3'd1, 5'd8},
        '{24'h123456, 1'b1, 1'b1, 16'hCAFE, 3'd1, 5'd8},
        '{24'h1FFFFF, 1'b0, 1'b1, 16'h0000, 3'd1, 5'd8},
        '{24'h050000, 1'b0, 1'b1, 16'h0000, NONE, 5'd0},
        '{24'h8ABCDE, 1'b0, 1'b0, 16'h0000, 3'd3, 5'd7},
        '{24'h8ABCDF, 1'b1, 1'b0, 16'h005A, 3'd3, 5'd7},
        '{24'h00ABCD, 1'b0, 1'b0, 16'h0000, 3'd0, 5'd2},
        '{24'hFFFFFF, 1'b0, 1'b1, 16'h0000, 3'd3, 5'd14},
        '{24'h7FFFFF, 1'b1, 1'b0, 16'h1111, NONE, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack, req_err;
    logic [15:0] req_rdata;
    logic [23:0] ext_addr;
    logic [15:0] ext_dout, ext_din;
    logic        ext_oe_n, ext_we_n;
    logic [3:0]  ext_cs_n;
    logic        ext_rdy = 1'b1;

    int errors = 0;
    int checks = 0;

    // observations of one request
    int          o_clk, o_we, o_oe, o_nph;
    logic [2:0]  o_win;
    logic        o_err, o_acked;
    logic [15:0] o_rdata;
    logic [23:0] o_ph_addr [0:1];
    logic [15:0] o_ph_dout [0:1];

    always #(CLK_PERIOD/2) clk = ~clk;

    // external memory model: lanes 7..0 give the low address byte
    assign ext_din = {ext_addr[7:0] ^ 8'hA5, ext_addr[7:0]};

    ebc_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base(BASE), .cfg_mask(MASK), .cfg_wait(WAIT), .cfg_wide(WIDE),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n), .ext_cs_n(ext_cs_n),
        .ext_rdy(ext_rdy)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [23:0] a, input logic wr, input logic sz,
                           input logic [15:0] wd, input int rdy_low);
        @(negedge clk);
        req_addr = a; req_write = wr; req_size = sz; req_wdata = wd; req_valid = 1'b1;
        o_clk = 0; o_we = 0; o_oe = 0; o_nph = 0; o_win = NONE;
        o_err = 1'b0; o_acked = 1'b0; o_rdata = '0;
        o_ph_addr[0] = '0; o_ph_addr[1] = '0; o_ph_dout[0] = '0; o_ph_dout[1] = '0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (ext_cs_n != 4'hF) begin
                for (int j = 0; j < 4; j++) if (!ext_cs_n[j]) o_win = 3'(j);
                if (o_nph == 0 || (o_nph < 2 && ext_addr != o_ph_addr[o_nph-1])) begin
                    o_ph_addr[o_nph] = ext_addr;
                    o_nph++;
                end
                if (!ext_we_n) begin o_we++; o_ph_dout[o_nph-1] = ext_dout; end
                if (!ext_oe_n) o_oe++;
                o_clk++;
            end
            ext_rdy = (o_clk > rdy_low);
            if (req_ack) begin
                o_acked = 1'b1; o_err = req_err; o_rdata = req_rdata;
                req_valid = 1'b0;
                break;
            end
        end
        ext_rdy = 1'b1;
    endtask

    function automatic logic [15:0] exp_rd(input logic [23:0] a, input logic sz, input logic wide);
        logic [23:0] a1 = a + 24'd1;
        if (!sz)      return {8'h00, a[7:0]};
        else if (wide) return {a[7:0] ^ 8'hA5, a[7:0]};
        else          return {a1[7:0], a[7:0]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ext_cs_n == 4'hF && ext_oe_n && ext_we_n, "R8 reset strobes", {ext_cs_n, ext_oe_n, ext_we_n}, 32'h3F);
        chk(!req_ack, "R12 reset ack", req_ack, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            vec_t  c = VEC[v];
            logic  wide = (c.win != NONE) && WIDE[c.win[1:0]];
            int    nph = (c.win == NONE) ? 0 : ((c.sz && !wide) ? 2 : 1);
            logic [23:0] a1 = c.addr + 24'd1;
            run_req(c.addr, c.wr, c.sz, c.wdata, 0);
            chk(o_acked, "R12 ack seen", o_acked, 1);
            chk(o_win == c.win, "R2 R3 R4 window", o_win, c.win);
            chk(o_err == (c.win == NONE), "R4 error flag", o_err, (c.win == NONE));
            chk(o_clk == int'(c.clks), "R5 R6 R10 cycle clocks", o_clk, c.clks);
            chk(o_nph == nph, "R10 phase count", o_nph, nph);
            if (nph > 0) chk(o_ph_addr[0] == c.addr, "R1 first address", o_ph_addr[0], c.addr);
            if (nph > 1) chk(o_ph_addr[1] == a1, "R1 R10 second address", o_ph_addr[1], a1);
            if (c.wr) begin
                chk(o_we == o_clk - nph && o_oe == 0, "R8 write strobes", {o_we[15:0], o_oe[15:0]}, {16'(o_clk - nph), 16'h0});
                if (nph == 1 && c.sz)
                    chk(o_ph_dout[0] == c.wdata, "R9 wide write data", o_ph_dout[0], c.wdata);
                if (nph == 1 && !c.sz)
                    chk(o_ph_dout[0][7:0] == c.wdata[7:0], "R11 byte write data", o_ph_dout[0][7:0], c.wdata[7:0]);
                if (nph == 2)
                    chk(o_ph_dout[0][7:0] == c.wdata[7:0] && o_ph_dout[1][7:0] == c.wdata[15:8],
                        "R10 split write bytes", {o_ph_dout[0][7:0], o_ph_dout[1][7:0]}, {c.wdata[7:0], c.wdata[15:8]});
            end else begin
                chk(o_oe == o_clk && o_we == 0, "R8 read strobes", {o_oe[15:0], o_we[15:0]}, {16'(o_clk), 16'h0});
                if (nph > 0)
                    chk(o_rdata == exp_rd(c.addr, c.sz, wide), "R9 R10 R11 R12 read data", o_rdata, exp_rd(c.addr, c.sz, wide));
            end
        end

        // R7: ready low for 4 clocks on a zero-wait window extends the cycle to 5 clocks
        run_req(24'h000040, 1'b0, 1'b1, 16'h0, 4);
        chk(o_clk == 5, "R7 ready stretches", o_clk, 5);
        chk(o_rdata == 16'hE540, "R7 R12 data after stretch", o_rdata, 16'hE540);
        // R7: ready low only during the 5 programmed waits has no effect
        run_req(24'h800100, 1'b0, 1'b0, 16'h0, 4);
        chk(o_clk == 7, "R7 ready ignored during waits", o_clk, 7);
        // R7: ready low past the waits of window 3
        run_req(24'h800100, 1'b0, 1'b0, 16'h0, 9);
        chk(o_clk == 10, "R7 ready after waits", o_clk, 10);
        // R12: ack lasts a single clock
        @(negedge clk);
        chk(!req_ack, "R12 ack single clock", req_ack, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule